// File: doc/BRIEF.md
# Isochronous IN Endpoint Status Controller

This block is the control and status logic for one isochronous IN endpoint of a USB device controller. Software reaches it through an 8-bit register port, with address decoding done outside, and uses that port to fill a double-buffered transmit packet store and to work one status register. The status register has several kinds of bit: a read-only service flag, two sticky flags that software clears by writing 1, a flush command that always reads 0, and a short-packet flag that software sets.

A buffer is handed to transmission by one of two events. It fills to the full packet size of 256 bytes, or software flags it as short. Buffers are handed over in the order they were filled.

The serial engine works the other side through a simple handshake. It requests a packet, pops bytes one at a time, and signals end of packet. A request with nothing ready counts as an underrun, and so does a pop past the end of the packet. The block does no bit encoding, no CRC and no token handling.

Top module: `iso_in_ep_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00000001. The only bit set is the service flag, bit 0.
- R2: Bits 31:8, 6, 5 and 4 of `csr_rdata` always read 0. The flush bit, bit 2, always reads 0.
- R3: A buffer that has received 256 data bytes becomes ready for transmission on its own, and `eng_ready` goes to 1. The engine then reads the bytes in write order. `eng_last` is 1 while the 256th byte is presented.
- R4: The service flag (bit 0) is 1 while at least one of the two buffers is empty, and 0 when both hold packets. Data writes made while both buffers are occupied are dropped.
- R5: Writing 1 to bit 7 marks the partly filled buffer as ready, and its packet length is the number of bytes written so far. Bit 7 reads 1 until the engine accepts that packet, then clears by itself.
- R6: Writing 1 to bit 7 while the current buffer is empty produces a zero-length packet. `eng_zlp` is 1 once the engine accepts it.
- R7: An end-of-packet while a packet is being sent does three things: it sets bit 1, it empties that buffer, and it ends the transfer. Writing 1 to bit 1 clears it. Writing 0 to it has no effect.
- R8: Bit 3 is set in either of two cases: a packet request arrives with no buffer ready, or a pop arrives after the last byte of the packet. No byte is consumed in either case. Writing 1 to bit 3 clears it.
- R9: Writing 1 to bit 2 empties both buffers and clears the byte counters and bit 7. It leaves bits 1 and 3 unchanged.
- R10: If hardware sets bit 1 or bit 3 in the same cycle that software writes 1 to clear it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_stat | input | 1 | Write strobe for the status register |
| csr_wr_data | input | 1 | Write strobe for the transmit data port |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 32 | Status register read value |
| eng_req | input | 1 | Engine requests the next packet |
| eng_pop | input | 1 | Engine consumes the presented byte |
| eng_eop | input | 1 | Engine reports the packet as sent |
| eng_ready | output | 1 | A packet is ready and no transfer is open |
| eng_data | output | 8 | Byte presented to the engine |
| eng_last | output | 1 | Presented byte is the final one of the packet |
| eng_zlp | output | 1 | Open transfer has zero length |

## Verification
Every input takes effect at the next rising edge. The status register and all engine outputs are decoded combinationally from registers, so each result is visible one cycle after its stimulus. That applies to the status bits, to the ready, last and zero-length signals, and to the byte presented after a pop.

The bench drives inputs on the falling edge and clears them on the following falling edge. It samples there, which is half a cycle after the edge that acted on the stimulus. Byte streams are checked one byte per cycle in that way.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
  localparam int unsigned PKT_BYTES_DEF = 256;
  localparam int unsigned B_SVC  = 0;
  localparam int unsigned B_DONE = 1;
  localparam int unsigned B_FLSH = 2;
  localparam int unsigned B_URUN = 3;
  localparam int unsigned B_SHRT = 7;
endpackage

// File: rtl/iso_in_txmem.sv
module iso_in_txmem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] bank_q [2][DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      bank_q[wbank][waddr] <= wdata;
    end
  end

  assign rdata = bank_q[rbank][raddr];
endmodule

// File: rtl/iso_in_bufctl.sv
module iso_in_bufctl #(
  parameter int unsigned PKT  = 256,
  localparam int unsigned AW  = $clog2(PKT),
  localparam int unsigned LW  = $clog2(PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic          flush,
  input  logic          short_set,
  input  logic          eng_req,
  input  logic          eng_pop,
  input  logic          eng_eop,
  output logic          mem_we,
  output logic          mem_wbank,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_rbank,
  output logic [AW-1:0] mem_raddr,
  output logic          svc,
  output logic          short_flag,
  output logic          ready,
  output logic          busy,
  output logic          last,
  output logic          zlp,
  output logic          urun_evt,
  output logic          done_evt
);
  localparam logic [LW-1:0] FULL_LEN = LW'(PKT);

  logic [1:0]          rdy_q, rdy_n;
  logic [LW-1:0]       len_q [2];
  logic [LW-1:0]       len_n [2];
  logic                wbuf_q, wbuf_n;
  logic                rbuf_q, rbuf_n;
  logic [LW-1:0]       wcnt_q, wcnt_n;
  logic [LW-1:0]       rptr_q, rptr_n;
  logic                busy_q, busy_n;
  logic                shrt_q, shrt_n;
  logic                sbuf_q, sbuf_n;
  logic                accept;
  logic [LW-1:0]       cur_len;

  assign accept  = data_we && !rdy_q[wbuf_q] && !flush;
  assign cur_len = len_q[rbuf_q];

  always_comb begin
    rdy_n    = rdy_q;
    len_n    = len_q;
    wbuf_n   = wbuf_q;
    rbuf_n   = rbuf_q;
    wcnt_n   = wcnt_q;
    rptr_n   = rptr_q;
    busy_n   = busy_q;
    shrt_n   = shrt_q;
    sbuf_n   = sbuf_q;
    urun_evt = 1'b0;
    done_evt = 1'b0;
    if (flush) begin
      rdy_n  = '0;
      wbuf_n = 1'b0;
      rbuf_n = 1'b0;
      wcnt_n = '0;
      rptr_n = '0;
      busy_n = 1'b0;
      shrt_n = 1'b0;
    end else begin
      if (accept) begin
        if (wcnt_q + 1'b1 == FULL_LEN) begin
          rdy_n[wbuf_q] = 1'b1;
          len_n[wbuf_q] = FULL_LEN;
          wbuf_n        = ~wbuf_q;
          wcnt_n        = '0;
        end else begin
          wcnt_n = wcnt_q + 1'b1;
        end
      end else if (short_set && !rdy_q[wbuf_q]) begin
        rdy_n[wbuf_q] = 1'b1;
        len_n[wbuf_q] = wcnt_q;
        shrt_n        = 1'b1;
        sbuf_n        = wbuf_q;
        wbuf_n        = ~wbuf_q;
        wcnt_n        = '0;
      end
      if (busy_q) begin
        if (eng_eop) begin
          rdy_n[rbuf_q] = 1'b0;
          rbuf_n        = ~rbuf_q;
          busy_n        = 1'b0;
          done_evt      = 1'b1;
        end else if (eng_pop) begin
          if (rptr_q < cur_len) begin
            rptr_n = rptr_q + 1'b1;
          end else begin
            urun_evt = 1'b1;
          end
        end
      end else if (eng_req) begin
        if (rdy_q[rbuf_q]) begin
          busy_n = 1'b1;
          rptr_n = '0;
          if (shrt_q && sbuf_q == rbuf_q) begin
            shrt_n = 1'b0;
          end
        end else begin
          urun_evt = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= '0;
      wbuf_q <= 1'b0;
      rbuf_q <= 1'b0;
      wcnt_q <= '0;
      rptr_q <= '0;
      busy_q <= 1'b0;
      shrt_q <= 1'b0;
      sbuf_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_n;
      wbuf_q <= wbuf_n;
      rbuf_q <= rbuf_n;
      wcnt_q <= wcnt_n;
      rptr_q <= rptr_n;
      busy_q <= busy_n;
      shrt_q <= shrt_n;
      sbuf_q <= sbuf_n;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[g] <= '0;
      end else if (len_n[g] != len_q[g]) begin
        len_q[g] <= len_n[g];
      end
    end
  end

  assign mem_we     = accept;
  assign mem_wbank  = wbuf_q;
  assign mem_waddr  = wcnt_q[AW-1:0];
  assign mem_rbank  = rbuf_q;
  assign mem_raddr  = rptr_q[AW-1:0];
  assign svc        = ~&rdy_q;
  assign short_flag = shrt_q;
  assign ready      = rdy_q[rbuf_q] && !busy_q;
  assign busy       = busy_q;
  assign last       = busy_q && (cur_len != '0) && (rptr_q + 1'b1 == cur_len);
  assign zlp        = busy_q && (cur_len == '0);
endmodule

// File: rtl/iso_in_csr.sv
module iso_in_csr
  import iso_in_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  wdata,
  input  logic        svc,
  input  logic        short_flag,
  input  logic        done_evt,
  input  logic        urun_evt,
  output logic        flush,
  output logic        short_set,
  output logic [31:0] rdata
);
  logic done_q, done_n;
  logic urun_q, urun_n;

  assign flush     = wr && wdata[B_FLSH];
  assign short_set = wr && wdata[B_SHRT];

  always_comb begin
    done_n = (done_q && !(wr && wdata[B_DONE])) || done_evt;
    urun_n = (urun_q && !(wr && wdata[B_URUN])) || urun_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      done_q <= done_n;
      urun_q <= urun_n;
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[B_SVC]  = svc;
    rdata[B_DONE] = done_q;
    rdata[B_URUN] = urun_q;
    rdata[B_SHRT] = short_flag;
  end
endmodule

// File: rtl/iso_in_ep_ctrl.sv
module iso_in_ep_ctrl #(
  parameter int unsigned PKT = iso_in_pkg::PKT_BYTES_DEF,
  localparam int unsigned AW = $clog2(PKT)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr_stat,
  input  logic        csr_wr_data,
  input  logic [7:0]  csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        eng_req,
  input  logic        eng_pop,
  input  logic        eng_eop,
  output logic        eng_ready,
  output logic [7:0]  eng_data,
  output logic        eng_last,
  output logic        eng_zlp
);
  logic          flush, short_set, svc, short_flag;
  logic          busy, urun_evt, done_evt;
  logic          mem_we, mem_wbank, mem_rbank;
  logic [AW-1:0] mem_waddr, mem_raddr;

  iso_in_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (csr_wr_stat),
    .wdata      (csr_wdata),
    .svc        (svc),
    .short_flag (short_flag),
    .done_evt   (done_evt),
    .urun_evt   (urun_evt),
    .flush      (flush),
    .short_set  (short_set),
    .rdata      (csr_rdata)
  );

  iso_in_bufctl #(.PKT(PKT)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_we    (csr_wr_data),
    .flush      (flush),
    .short_set  (short_set),
    .eng_req    (eng_req),
    .eng_pop    (eng_pop),
    .eng_eop    (eng_eop),
    .mem_we     (mem_we),
    .mem_wbank  (mem_wbank),
    .mem_waddr  (mem_waddr),
    .mem_rbank  (mem_rbank),
    .mem_raddr  (mem_raddr),
    .svc        (svc),
    .short_flag (short_flag),
    .ready      (eng_ready),
    .busy       (busy),
    .last       (eng_last),
    .zlp        (eng_zlp),
    .urun_evt   (urun_evt),
    .done_evt   (done_evt)
  );

  iso_in_txmem #(.DEPTH(PKT), .DW(8)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .wbank (mem_wbank),
    .waddr (mem_waddr),
    .wdata (csr_wdata),
    .rbank (mem_rbank),
    .raddr (mem_raddr),
    .rdata (eng_data)
  );
endmodule

// File: rtl/iso_in_ep_chk.sv
module iso_in_ep_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_wr_stat,
  input logic [7:0]  csr_wdata,
  input logic [31:0] csr_rdata,
  input logic        eng_req,
  input logic        eng_eop,
  input logic        eng_ready,
  input logic        busy
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:8] == '0) && (csr_rdata[6:4] == '0) && !csr_rdata[2]);

  assert_both_full_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[0] |-> (eng_ready || busy));

  assert_eop_sets_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_eop) |=> csr_rdata[1]);

  assert_eop_ends_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_eop && !(csr_wr_stat && csr_wdata[2])) |=> (!busy && csr_rdata[0]));

  assert_req_empty_urun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ready && !busy && !(csr_wr_stat && csr_wdata[2])) |=> csr_rdata[3]);

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_stat && csr_wdata[2]) |=> (!eng_ready && !busy && !csr_rdata[7] && csr_rdata[0]));

  assert_flush_keeps_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_stat && csr_wdata[2] && !csr_wdata[1] && csr_rdata[1]) |=> csr_rdata[1]);
endmodule

bind iso_in_ep_ctrl iso_in_ep_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_wr_stat (csr_wr_stat),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .eng_req     (eng_req),
  .eng_eop     (eng_eop),
  .eng_ready   (eng_ready),
  .busy        (busy)
);

// File: tb/sim_iso_in_ep_ctrl.sv
module sim_iso_in_ep_ctrl;
  logic        clk, rst_n;
  logic        csr_wr_stat, csr_wr_data;
  logic [7:0]  csr_wdata;
  logic [31:0] csr_rdata;
  logic        eng_req, eng_pop, eng_eop;
  logic        eng_ready, eng_last, eng_zlp;
  logic [7:0]  eng_data;
  int          n_run, n_fail;
  bit          done;

  iso_in_ep_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .csr_wr_stat(csr_wr_stat), .csr_wr_data(csr_wr_data),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .eng_req(eng_req), .eng_pop(eng_pop),
    .eng_eop(eng_eop), .eng_ready(eng_ready), .eng_data(eng_data), .eng_last(eng_last),
    .eng_zlp(eng_zlp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // op: 0 status write, 1 data write, 2 engine request, 3 end of packet
  typedef struct packed { logic [1:0] op; logic [7:0] wd; logic [7:0] exp; } vec_t;
  localparam vec_t VEC [12] = '{
    '{2'd0, 8'h00, 8'h01},   // R1 write of zero changes nothing
    '{2'd0, 8'h70, 8'h01},   // R2 reserved bits stay 0
    '{2'd1, 8'hA5, 8'h01},   // one byte into buffer
    '{2'd0, 8'h80, 8'h81},   // R5 short packet flagged
    '{2'd2, 8'h00, 8'h01},   // R5 flag clears on accept
    '{2'd3, 8'h00, 8'h03},   // R7 completion flag set
    '{2'd0, 8'h02, 8'h01},   // R7 write 1 clears
    '{2'd2, 8'h00, 8'h09},   // R8 request with nothing ready
    '{2'd0, 8'h04, 8'h09},   // R9 flush keeps underrun, reads 0 at bit 2
    '{2'd0, 8'h08, 8'h01},   // R8 write 1 clears underrun
    '{2'd0, 8'h80, 8'h81},   // R6 short on empty buffer
    '{2'd0, 8'h04, 8'h01}    // R9 flush clears short flag
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] wd);
    @(negedge clk);
    csr_wdata   = wd;
    csr_wr_stat = (op == 2'd0);
    csr_wr_data = (op == 2'd1);
    eng_req     = (op == 2'd2);
    eng_eop     = (op == 2'd3);
    @(negedge clk);
    csr_wr_stat = 1'b0; csr_wr_data = 1'b0; eng_req = 1'b0; eng_eop = 1'b0;
  endtask

  task automatic pop1;
    @(negedge clk);
    eng_pop = 1'b1;
    @(negedge clk);
    eng_pop = 1'b0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; csr_wr_stat = 1'b0; csr_wr_data = 1'b0; csr_wdata = '0;
    eng_req = 1'b0; eng_pop = 1'b0; eng_eop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset value", csr_rdata, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", csr_rdata, 32'h1);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i].op, VEC[i].wd);
      chk($sformatf("R2/R5-R9 vector %0d", i), csr_rdata, {24'h0, VEC[i].exp});
    end

    // R3/R4: fill both buffers
    for (int i = 0; i < 256; i++) begin
      step(2'd1, 8'(i));
      if (i == 254) chk("R3 not ready before 256th byte", {31'h0, eng_ready}, 32'h0);
    end
    chk("R3 ready after 256 bytes", {31'h0, eng_ready}, 32'h1);
    chk("R4 one buffer free", csr_rdata, 32'h1);
    for (int i = 0; i < 256; i++) step(2'd1, 8'(i + 7));
    chk("R4 both full", csr_rdata, 32'h0);
    step(2'd1, 8'hEE);
    chk("R4 write while full dropped", csr_rdata, 32'h0);

    step(2'd2, 8'h00);
    for (int i = 0; i < 256; i++) begin
      if (eng_data !== 8'(i)) chk("R3 byte order pkt0", {24'h0, eng_data}, 32'(8'(i)));
      if (i == 255) chk("R3 last flag", {31'h0, eng_last}, 32'h1);
      if (i == 0) chk("R3 not last at start", {31'h0, eng_last}, 32'h0);
      pop1();
    end
    step(2'd3, 8'h00);
    chk("R7 done and free", csr_rdata, 32'h3);

    // R10: end of packet and clear in same cycle
    step(2'd2, 8'h00);
    for (int i = 0; i < 256; i++) begin
      if (eng_data !== 8'(i + 7)) chk("R4 pkt1 content intact", {24'h0, eng_data}, 32'(8'(i + 7)));
      pop1();
    end
    chk("R8 no underrun yet", {31'h0, csr_rdata[3]}, 32'h0);
    pop1();
    chk("R8 pop past end", csr_rdata, 32'h0B);
    @(negedge clk);
    csr_wr_stat = 1'b1; csr_wdata = 8'h02; eng_eop = 1'b1;
    @(negedge clk);
    csr_wr_stat = 1'b0; eng_eop = 1'b0;
    chk("R10 set beats clear", csr_rdata, 32'h0B);
    step(2'd0, 8'h0A);
    chk("R7/R8 write 1 clears both", csr_rdata, 32'h01);
    step(2'd0, 8'h00);
    chk("R7 write 0 no effect", csr_rdata, 32'h01);

    // R6: zero-length packet
    step(2'd0, 8'h80);
    step(2'd2, 8'h00);
    chk("R6 zlp flag", {30'h0, eng_zlp, eng_last}, 32'h2);
    step(2'd3, 8'h00);
    chk("R6 zlp completes", csr_rdata, 32'h3);

    // R5: short of 3 bytes, R9 flush mid-fill
    step(2'd1, 8'h11); step(2'd1, 8'h22); step(2'd1, 8'h33);
    step(2'd0, 8'h80);
    step(2'd2, 8'h00);
    chk("R5 short first byte", {24'h0, eng_data}, 32'h11);
    pop1(); pop1();
    chk("R5 short last byte", {23'h0, eng_last, eng_data}, 32'h133);
    step(2'd0, 8'h04);
    chk("R9 flush keeps done", csr_rdata, 32'h03);
    chk("R9 flush empties", {31'h0, eng_ready}, 32'h0);
    step(2'd1, 8'h44);
    step(2'd0, 8'h84);
    chk("R9 flush beats short", csr_rdata, 32'h03);
    step(2'd0, 8'h80);
    step(2'd2, 8'h00);
    chk("R9 counter cleared by flush", {31'h0, eng_zlp}, 32'h1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule